// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus unit and an instruction decoder. It requests aligned 32-bit code words ahead of need and keeps them in a 16-byte ring of four rows. It hands the decoder one byte per cycle from the head of the ring. The bus side is a request/response pair. Requests are accepted by a ready signal, and responses come back in request order, carrying the word data but no address. The decoder sees a byte-valid flag and a byte value, and pulls a byte with a take strobe.

A redirect input serves taken branches. It empties the ring and restarts fetching from the word that contains the new target. When the target is unaligned, the bytes before it in that first word are skipped. Words requested before the redirect are still owed by the bus unit. They are counted and thrown away when they arrive. Prefetching pauses when the word address of the fetch pointer equals the word address of the code segment limit.

The instruction pointer of the next byte is not held in a register. It is formed from the fetch pointer by removing the bytes already claimed: bytes held, plus words in flight, less any skipped leading bytes.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty (byte_valid low), `ip_out` equals the reset address, and the first request addresses the aligned word holding it.
- R2: Every request address has bits [1:0] equal to zero. After each accepted request, the next request addresses the following word (+4), until a redirect occurs.
- R3: No request is raised while `req_addr[31:2]` equals `seg_limit[31:2]`; bits [1:0] of the limit play no part.
- R4: A request is raised only if held bytes, skipped bytes and four bytes per live outstanding word leave room for four more bytes in the 16-byte ring. At most two requests, live or discarded, are ever outstanding.
- R5: Bytes reach the decoder in address order. Byte k of a returned word is `rsp_data[8k+7:8k]`, so the lowest address sits in the least significant byte.
- R6: `ip_out` always equals the address of the byte at the head of the queue. It advances by one per consumed byte and changes for nothing else except a redirect.
- R7: A redirect empties the queue, so byte_valid is low in the following cycle, and the next request addresses the aligned word containing the target.
- R8: After a redirect to an unaligned target, the first byte delivered is the byte at the target address, and `ip_out` equals the target.
- R9: Responses to requests issued before a redirect never enter the queue.
- R10: A redirect takes priority over a response and a take in the same cycle. Neither the response nor the take has an effect, and no request is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_limit | input | 32 | Code segment limit; only bits [31:2] compared |
| redirect_valid | input | 1 | Branch redirect strobe; flushes the queue |
| redirect_addr | input | 32 | Redirect target byte address |
| req_valid | output | 1 | Fetch request to the bus unit |
| req_ready | input | 1 | Bus unit accepts the request |
| req_addr | output | 32 | Aligned word address of the request |
| rsp_valid | input | 1 | Returned word is present (in request order) |
| rsp_data | input | 32 | Returned word, lowest address in bits [7:0] |
| byte_valid | output | 1 | Head byte available |
| byte_data | output | 8 | Head byte |
| byte_take | input | 1 | Decoder consumes the head byte |
| ip_out | output | 32 | Address of the head byte |

## Verification
The bench targets four cases. The first is a redirect while two words are still owed. A design that let those late words into the ring would hand the decoder bytes from the old stream, and the byte comparison catches that. The second is a redirect to an odd target. Wrong skip handling would show either a leading byte from below the target or an instruction pointer shifted by the offset. The third is a queue that fills because nothing is consumed, where a design with a wrong space count would issue a fifth request. The fourth is a limit with nonzero low bits. A design that compared the full limit would fetch the limit word, and a design that compared the wrong bits would never stop.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int unsigned PFQ_LANES  = 4;
    localparam int unsigned PFQ_LANE_W = 8;
endpackage

// File: rtl/pfq_rows.sv
module pfq_rows #(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned LANES  = pfq_pkg::PFQ_LANES,
    parameter int unsigned LANE_W = pfq_pkg::PFQ_LANE_W,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned LI_W   = $clog2(LANES),
    localparam int unsigned IDX_W  = ROW_W + LI_W,
    localparam int unsigned WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_lane
);
    logic [WORD_W-1:0] row_q [ROWS];
    logic [ROW_W-1:0]  sel_row;
    logic [LI_W-1:0]   sel_lane;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (wr_en && (wr_row == ROW_W'(r))) begin
                row_q[r] <= wr_word;
            end
        end
    end

    assign sel_row  = rd_idx[IDX_W-1:LI_W];
    assign sel_lane = rd_idx[LI_W-1:0];

    always_comb begin
        rd_lane = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sel_lane == LI_W'(l)) begin
                rd_lane = row_q[sel_row][l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/pfq_limit_cmp.sv
module pfq_limit_cmp #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LI_W   = 2,
    localparam int unsigned HI_W  = ADDR_W - LI_W
) (
    input  logic [HI_W-1:0]   ptr_hi,
    input  logic [ADDR_W-1:0] limit,
    output logic              at_limit
);
    assign at_limit = (ptr_hi == limit[ADDR_W-1:LI_W]);
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ROWS    = 4,
    parameter int unsigned MAX_OUT = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int unsigned LANES  = pfq_pkg::PFQ_LANES,
    localparam int unsigned LANE_W = pfq_pkg::PFQ_LANE_W,
    localparam int unsigned WORD_W = LANES * LANE_W,
    localparam int unsigned LI_W   = $clog2(LANES),
    localparam int unsigned CAP    = ROWS * LANES,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned IDX_W  = ROW_W + LI_W,
    localparam int unsigned CNT_W  = $clog2(CAP + 1),
    localparam int unsigned OUT_W  = $clog2(MAX_OUT + 1),
    localparam int unsigned HI_W   = ADDR_W - LI_W,
    localparam int unsigned RES_W  = CNT_W + OUT_W + LI_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              byte_valid,
    output logic [LANE_W-1:0] byte_data,
    input  logic              byte_take,
    output logic [ADDR_W-1:0] ip_out
);
    typedef struct packed {
        logic [HI_W-1:0]  fptr;
        logic [IDX_W-1:0] head;
        logic [ROW_W-1:0] wrow;
        logic [CNT_W-1:0] cnt;
        logic [LI_W-1:0]  skip;
        logic [OUT_W-1:0] live;
        logic [OUT_W-1:0] drop;
    } pfq_st_t;

    pfq_st_t st_d, st_q;

    logic             at_limit;
    logic             take_ok;
    logic             rsp_keep;
    logic             fire;
    logic             wr_en;
    logic             can_req;
    logic [RES_W-1:0] resv;
    logic [OUT_W:0]   inflight;

    pfq_limit_cmp #(.ADDR_W(ADDR_W), .LI_W(LI_W)) u_lim (
        .ptr_hi   (st_q.fptr),
        .limit    (seg_limit),
        .at_limit (at_limit)
    );

    pfq_rows #(.ROWS(ROWS), .LANES(LANES), .LANE_W(LANE_W)) u_rows (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (st_q.wrow),
        .wr_word (rsp_data),
        .rd_idx  (st_q.head),
        .rd_lane (byte_data)
    );

    // space claimed in the ring: held bytes, skipped lead bytes, words owed
    assign resv = RES_W'(st_q.cnt) + RES_W'(st_q.skip)
                + RES_W'(st_q.live) * RES_W'(LANES);
    assign inflight = (OUT_W+1)'(st_q.live) + (OUT_W+1)'(st_q.drop);
    assign can_req  = !at_limit
                   && (inflight < (OUT_W+1)'(MAX_OUT))
                   && ((resv + RES_W'(LANES)) <= RES_W'(CAP));

    assign req_valid  = can_req && !redirect_valid;
    assign req_addr   = {st_q.fptr, {LI_W{1'b0}}};
    assign fire       = req_valid && req_ready;
    assign take_ok    = byte_take && (st_q.cnt != '0);
    assign rsp_keep   = rsp_valid && (st_q.drop == '0);
    assign byte_valid = (st_q.cnt != '0);
    assign ip_out     = req_addr - ADDR_W'(st_q.cnt)
                      - ADDR_W'(st_q.live) * ADDR_W'(LANES)
                      + ADDR_W'(st_q.skip);

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (redirect_valid) begin
            st_d.fptr = redirect_addr[ADDR_W-1:LI_W];
            st_d.head = IDX_W'(redirect_addr[LI_W-1:0]);
            st_d.skip = redirect_addr[LI_W-1:0];
            st_d.wrow = '0;
            st_d.cnt  = '0;
            st_d.live = '0;
            st_d.drop = OUT_W'(inflight - (OUT_W+1)'(rsp_valid));
        end else begin
            if (fire) begin
                st_d.fptr = st_q.fptr + HI_W'(1);
            end
            if (rsp_valid) begin
                if (st_q.drop != '0) begin
                    st_d.drop = st_q.drop - OUT_W'(1);
                end else begin
                    wr_en     = 1'b1;
                    st_d.wrow = st_q.wrow + ROW_W'(1);
                    st_d.cnt  = st_q.cnt + CNT_W'(LANES) - CNT_W'(st_q.skip);
                    st_d.skip = '0;
                end
            end
            st_d.live = st_q.live + OUT_W'(fire) - OUT_W'(rsp_keep);
            if (take_ok) begin
                st_d.head = st_q.head + IDX_W'(1);
                st_d.cnt  = st_d.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fptr <= RESET_ADDR[ADDR_W-1:LI_W];
            st_q.head <= IDX_W'(RESET_ADDR[LI_W-1:0]);
            st_q.skip <= RESET_ADDR[LI_W-1:0];
            st_q.wrow <= '0;
            st_q.cnt  <= '0;
            st_q.live <= '0;
            st_q.drop <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pfq_top_chk.sv
module pfq_top_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned MAX_OUT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] seg_limit,
    input logic              redirect_valid,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              byte_valid,
    input logic              byte_take,
    input logic [ADDR_W-1:0] ip_out
);
    logic [3:0] owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            owed_q <= owed_q + 4'(req_valid && req_ready) - 4'(rsp_valid);
        end
    end

    // R4
    owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= 4'(MAX_OUT));

    // R2
    next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) ##1 req_valid |-> req_addr == $past(req_addr) + ADDR_W'(4));

    // R3
    limit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[ADDR_W-1:2] != seg_limit[ADDR_W-1:2]);

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !byte_valid);

    // R10
    flush_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !req_valid);

    // R6
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_take && !redirect_valid) |=> ip_out == $past(ip_out) + ADDR_W'(1));

    // R6
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_take && !redirect_valid) |=> $stable(ip_out));
endmodule

bind pfq_top pfq_top_chk #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) u_chk (.*);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seg_limit = 32'hFFFF_FFF0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_addr = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_take = 1'b0;
    logic [31:0] ip_out;

    always #2 clk = ~clk;

    pfq_top u0 (.*);

    int unsigned checks = 0;
    int unsigned fails = 0;
    logic [31:0] exp_addr = 32'h0;
    logic [31:0] exp_req = 32'h0;
    logic [31:0] fifo [8];
    int unsigned f_rd = 0, f_wr = 0, f_n = 0;
    int unsigned reqs = 0;
    bit          prev_rd = 1'b0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd2654435761;
        return t[31:24] ^ a[7:0];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input bit rd, input logic [31:0] tgt, input bit tk, input bit rdy, input bit rsp_ok);
        redirect_valid = rd;
        redirect_addr  = tgt;
        byte_take      = tk;
        req_ready      = rdy;
        rsp_valid      = rsp_ok && (f_n > 0);
        rsp_data       = (f_n > 0) ? mem_word(fifo[f_rd]) : 32'h0;
        #1;
        if (prev_rd) begin
            check(!byte_valid, "R7 empty after redirect", 32'(byte_valid), 32'h0);
            check(ip_out == exp_addr, "R8 ip equals target", ip_out, exp_addr);
        end
        if (!rd && tk && byte_valid) begin
            check(byte_data == mem_byte(exp_addr), "R5 byte order", 32'(byte_data), 32'(mem_byte(exp_addr)));
            check(ip_out == exp_addr, "R6 ip at head", ip_out, exp_addr);
            exp_addr = exp_addr + 32'd1;
        end
        if (req_valid) begin
            check(!rd, "R10 no request during redirect", 32'(req_valid), 32'h0);
            check(req_addr == exp_req, "R2 request address", req_addr, exp_req);
            check(req_addr[31:2] != seg_limit[31:2], "R3 limit respected", req_addr, seg_limit);
            if (rdy) begin
                fifo[f_wr] = req_addr;
                f_wr = (f_wr + 1) % 8;
                f_n++;
                reqs++;
                exp_req = exp_req + 32'd4;
            end
        end
        if (rsp_valid) begin
            f_rd = (f_rd + 1) % 8;
            f_n--;
        end
        check(f_n <= 2, "R4 outstanding bound", 32'(f_n), 32'd2);
        if (rd) begin
            exp_addr = tgt;
            exp_req  = {tgt[31:2], 2'b00};
        end
        prev_rd = rd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(!byte_valid, "R1 empty after reset", 32'(byte_valid), 32'h0);
        check(ip_out == 32'h0, "R1 ip at reset address", ip_out, 32'h0);
        check(req_valid && req_addr == 32'h0, "R1 first request", req_addr, 32'h0);
        @(posedge clk);
        #1;
        // R1 request was not accepted yet, so exp_req stays 0
        // R4: fill with nothing consumed
        cycle(1'b1, 32'h100, 1'b0, 1'b1, 1'b1);
        reqs = 0;
        repeat (30) cycle(1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
        check(reqs == 4, "R4 ring full after four words", 32'(reqs), 32'd4);
        check(!req_valid, "R4 no request when full", 32'(req_valid), 32'h0);
        repeat (20) cycle(1'b0, 32'h0, 1'b1, 1'b1, 1'b1);
        check(exp_addr == 32'h114, "R5 drained in order", exp_addr, 32'h114);
        // R8: unaligned target
        cycle(1'b1, 32'h203, 1'b1, 1'b1, 1'b1);
        repeat (30) cycle(1'b0, 32'h0, 1'b1, 1'b1, 1'b1);
        check(exp_addr > 32'h210, "R8 progress from odd target", exp_addr, 32'h211);
        // R3: limit with nonzero low bits
        seg_limit = 32'h0000_030F;
        cycle(1'b1, 32'h300, 1'b1, 1'b1, 1'b1);
        reqs = 0;
        repeat (40) cycle(1'b0, 32'h0, 1'b1, 1'b1, 1'b1);
        check(reqs == 3, "R3 stops at limit word", 32'(reqs), 32'd3);
        check(exp_addr == 32'h30C, "R3 bytes before limit", exp_addr, 32'h30C);
        check(!byte_valid, "R3 queue drained", 32'(byte_valid), 32'h0);
        seg_limit = 32'hFFFF_FFF0;
        // R9 and R10: redirect while two words owed, with rsp and take colliding
        cycle(1'b1, 32'h400, 1'b0, 1'b1, 1'b0);
        repeat (3) cycle(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
        check(f_n == 2, "R9 two words owed", 32'(f_n), 32'd2);
        cycle(1'b1, 32'h501, 1'b1, 1'b1, 1'b1);
        repeat (25) cycle(1'b0, 32'h0, 1'b1, 1'b1, 1'b1);
        check(exp_addr > 32'h508, "R9 new stream delivered", exp_addr, 32'h509);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit rd = ($urandom % 40) == 0;
            logic [31:0] tgt = $urandom % 32'h1_0000;
            cycle(rd, tgt, ($urandom % 10) < 6, ($urandom % 10) < 7, ($urandom % 2) == 1);
        end
        check(exp_addr != 32'h0, "R5 random stream advanced", exp_addr, 32'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule